// File: doc/BRIEF.md
# A/D Conversion Timing Sequencer

This block controls when a 10-bit successive-approximation converter samples, converts and hands over its result. The converter sits inside a processor whose machine cycle lasts six input clocks. The block divides the input clock into machine cycles and brings out a strobe in the last clock of each one. A conversion is requested in one of two ways. Software writes to the result-low register, and the data of that write has no effect. The other way is a falling edge on an active-low external start pin. Whichever way it is requested, a conversion always begins on a machine-cycle boundary.

A conversion runs for 8 or 16 machine cycles, as a length select sampled at the start decides. The machine cycle that follows is a result-write cycle. In its first clock the converted value appears on the result port, busy drops and the interrupt request rises. In continuous mode the next conversion begins at the boundary that ends the write cycle. The converted value itself comes from outside the block, on `ain_code`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `mc_tick` is high in exactly one clock out of every 6: the last clock of each machine cycle. The first machine cycle begins in the first clock after reset is released.
- R2: A one-clock pulse on `res_lo_wr` requests a conversion. A falling edge on `start_n` also requests one. The pin passes through two synchronising flip-flops before edge detection. A rising edge on `start_n` requests nothing.
- R3: `busy` rises only in the clock that directly follows a clock with `mc_tick` high.
- R4: `busy` stays high for exactly 48 clocks (8 machine cycles) when `ctl_long` is 0 at the start, and for exactly 96 clocks (16 machine cycles) when it is 1. A change of `ctl_long` during a conversion does not change that conversion's length.
- R5: `result` takes the value of `ain_code` at the clock edge where `busy` falls, so it is valid in the first clock of the write cycle. At no other time does `result` change.
- R6: When a conversion completes, `busy` falls and `irq_req` is high in that same clock.
- R7: If `ctl_cont` is 1 during the write cycle, `busy` stays low for exactly one machine cycle (6 clocks) and then a new conversion begins.
- R8: If `ctl_cont` is cleared during a conversion, that conversion finishes normally and no further conversion starts.
- R9: A request that arrives while `busy` is high is dropped. It does not lengthen the running conversion and it does not start another one afterwards.
- R10: `irq_req` stays high until a one-clock `irq_clr` pulse, and it is low in the next clock. A completion in the same clock as the clear wins, and the flag then stays set.
- R11: After reset, `busy` and `irq_req` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; six periods form one machine cycle |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| res_lo_wr | input | 1 | Bus write strobe to the result-low register; starts a conversion |
| start_n | input | 1 | Asynchronous external start pin; a falling edge starts a conversion |
| ctl_cont | input | 1 | Continuous-conversion mode enable |
| ctl_long | input | 1 | Length select: 0 gives 8 machine cycles, 1 gives 16 |
| irq_clr | input | 1 | Software clear of the interrupt request flag |
| ain_code | input | 10 | Converted value supplied by the analog stub |
| mc_tick | output | 1 | High in the last clock of every machine cycle |
| busy | output | 1 | High while a conversion is in progress |
| irq_req | output | 1 | Conversion-complete interrupt request flag |
| result | output | 10 | Result register, readable in the write cycle |

## Verification
The assertions assume that `ain_code` is only meaningful at the completion edge. They also assume that `irq_clr`, `res_lo_wr`, `ctl_cont` and `ctl_long` are synchronous single-clock or level inputs that change away from the active edge. Only `start_n` may change at any time. The bench drives every synchronous input on the falling clock edge and pulses the strobes for exactly one clock. It never clears the interrupt flag in the final clock of a conversion, so the clear-versus-set rule is covered by the assertion's exclusion rather than by a race in the stimulus.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Sequencer phase: waiting, converting, or in the result-write cycle
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_t;

   localparam int unsigned DEF_PH_PER_MC = 6;
   localparam int unsigned DEF_SHORT_MC  = 8;
   localparam int unsigned DEF_LONG_MC   = 16;
   localparam int unsigned DEF_RES_W     = 10;
   localparam int unsigned DEF_SYNC      = 2;

endpackage

// File: rtl/adc_seq_mcgen.sv
// Machine-cycle phase generator: one strobe per PH_PER_MC input clocks.
module adc_seq_mcgen #(
   parameter int unsigned PH_PER_MC = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic mc_last
);
   localparam int unsigned PW = (PH_PER_MC > 1) ? $clog2(PH_PER_MC) : 1;
   localparam logic [PW-1:0] PH_END = PW'(PH_PER_MC - 1);

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (ph_q == PH_END) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign mc_last = (ph_q == PH_END);

endmodule

// File: rtl/adc_seq_trig.sv
// Start request capture: pin synchroniser, falling-edge detect, pending latch.
module adc_seq_trig #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n,
   input  logic bus_start,
   input  logic busy,
   input  logic launch,
   output logic trig_req
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_fall;
   logic                   req_new;
   logic                   pend_q;

   // Idle level of the pin is high, so the chain resets to ones
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], start_n};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pin_fall = prev_q & ~sync_q[SYNC_STAGES-1];

   // Requests seen while converting are dropped, not remembered
   assign req_new = (bus_start | pin_fall) & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (launch) begin
         pend_q <= 1'b0;
      end else if (req_new) begin
         pend_q <= 1'b1;
      end
   end

   assign trig_req = pend_q | req_new;

endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion sequencer: counts machine cycles through the conversion and write cycle.
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned SHORT_MC = 8,
   parameter int unsigned LONG_MC  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_last,
   input  logic trig_req,
   input  logic cont_en,
   input  logic long_sel,
   output logic busy,
   output logic launch,
   output logic done
);
   localparam int unsigned CW = $clog2(LONG_MC + 1);
   localparam logic [CW-1:0] SHORT_END = CW'(SHORT_MC - 1);
   localparam logic [CW-1:0] LONG_END  = CW'(LONG_MC - 1);

   seq_state_t    state_q;
   logic [CW-1:0] mcnt_q;
   logic          long_q;
   logic [CW-1:0] end_cnt;

   // The length choice only exists when the two lengths differ
   generate
      if (SHORT_MC == LONG_MC) begin : g_fixed_len
         assign end_cnt = SHORT_END;
      end else begin : g_sel_len
         assign end_cnt = long_q ? LONG_END : SHORT_END;
      end
   endgenerate

   assign launch = mc_last &
                   (((state_q == ST_WRITE) & cont_en) |
                    ((state_q != ST_CONV) & trig_req));

   assign done = mc_last & (state_q == ST_CONV) & (mcnt_q == end_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mcnt_q  <= '0;
         long_q  <= 1'b0;
      end else if (launch) begin
         state_q <= ST_CONV;
         mcnt_q  <= '0;
         long_q  <= long_sel;
      end else if (done) begin
         state_q <= ST_WRITE;
      end else if (mc_last && state_q == ST_CONV) begin
         mcnt_q  <= mcnt_q + 1'b1;
      end else if (mc_last && state_q == ST_WRITE) begin
         state_q <= ST_IDLE;
      end
   end

   assign busy = (state_q == ST_CONV);

endmodule

// File: rtl/adc_seq_result.sv
// Result register and interrupt request flag.
module adc_seq_result #(
   parameter int unsigned RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             irq_clr,
   input  logic [RES_W-1:0] ain_code,
   output logic [RES_W-1:0] result,
   output logic             irq_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
      end else if (done) begin
         result <= ain_code;
      end
   end

   // Completion takes priority over a simultaneous software clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
      end else if (done) begin
         irq_req <= 1'b1;
      end else if (irq_clr) begin
         irq_req <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top level of the A/D conversion timing sequencer.
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned PH_PER_MC   = DEF_PH_PER_MC,
   parameter int unsigned SHORT_MC    = DEF_SHORT_MC,
   parameter int unsigned LONG_MC     = DEF_LONG_MC,
   parameter int unsigned RES_W       = DEF_RES_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_lo_wr,
   input  logic             start_n,
   input  logic             ctl_cont,
   input  logic             ctl_long,
   input  logic             irq_clr,
   input  logic [RES_W-1:0] ain_code,
   output logic             mc_tick,
   output logic             busy,
   output logic             irq_req,
   output logic [RES_W-1:0] result
);
   // Elaboration-time parameter checks
   generate
      if (PH_PER_MC < 2) begin : g_bad_ph
         $error("adc_seq_ctrl: PH_PER_MC must be at least 2");
      end
      if (SHORT_MC < 1 || LONG_MC < SHORT_MC) begin : g_bad_len
         $error("adc_seq_ctrl: need 1 <= SHORT_MC <= LONG_MC");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("adc_seq_ctrl: SYNC_STAGES must be at least 2");
      end
      if (RES_W < 1) begin : g_bad_w
         $error("adc_seq_ctrl: RES_W must be positive");
      end
   endgenerate

   logic mc_last;
   logic trig_req;
   logic launch;
   logic done;
   logic busy_i;

   adc_seq_mcgen #(
      .PH_PER_MC (PH_PER_MC)
   ) u_mcgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .mc_last (mc_last)
   );

   adc_seq_trig #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_n   (start_n),
      .bus_start (res_lo_wr),
      .busy      (busy_i),
      .launch    (launch),
      .trig_req  (trig_req)
   );

   adc_seq_fsm #(
      .SHORT_MC (SHORT_MC),
      .LONG_MC  (LONG_MC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mc_last  (mc_last),
      .trig_req (trig_req),
      .cont_en  (ctl_cont),
      .long_sel (ctl_long),
      .busy     (busy_i),
      .launch   (launch),
      .done     (done)
   );

   adc_seq_result #(
      .RES_W (RES_W)
   ) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .irq_clr  (irq_clr),
      .ain_code (ain_code),
      .result   (result),
      .irq_req  (irq_req)
   );

   assign mc_tick = mc_last;
   assign busy    = busy_i;

endmodule

// File: rtl/adc_seq_chk.sv
// Property checker for adc_seq_ctrl, attached by bind.
module adc_seq_chk #(
   parameter int unsigned PH_PER_MC = 6,
   parameter int unsigned SHORT_MC  = 8,
   parameter int unsigned LONG_MC   = 16,
   parameter int unsigned RES_W     = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mc_tick,
   input logic             busy,
   input logic             irq_req,
   input logic             irq_clr,
   input logic [RES_W-1:0] result
);
   localparam int unsigned RLW = $clog2(LONG_MC * PH_PER_MC + 2);
   localparam int unsigned GW  = $clog2(PH_PER_MC + 1);

   logic [RLW-1:0] run_len;
   logic [GW-1:0]  gap;

   // Clocks spent busy in the current run
   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   // Clocks since the last tick (or since reset)
   always_ff @(posedge clk) begin
      if (!rst_n)       gap <= '0;
      else if (mc_tick) gap <= '0;
      else              gap <= gap + 1'b1;
   end

   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mc_tick |-> (gap == GW'(PH_PER_MC - 1)));

   assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mc_tick));

   assert_conv_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == RLW'(SHORT_MC * PH_PER_MC) ||
                       run_len == RLW'(LONG_MC * PH_PER_MC)));

   assert_result_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (result != $past(result)) |-> $fell(busy));

   assert_irq_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_req);

   assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !(busy && mc_tick)) |=> !irq_req);

endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .PH_PER_MC (PH_PER_MC),
   .SHORT_MC  (SHORT_MC),
   .LONG_MC   (LONG_MC),
   .RES_W     (RES_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mc_tick (mc_tick),
   .busy    (busy),
   .irq_req (irq_req),
   .irq_clr (irq_clr),
   .result  (result)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int MC         = 6;
   localparam int SHORT_LEN  = 8 * MC;
   localparam int LONG_LEN   = 16 * MC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       res_lo_wr = 1'b0;
   logic       start_n = 1'b1;
   logic       ctl_cont = 1'b0;
   logic       ctl_long = 1'b0;
   logic       irq_clr = 1'b0;
   logic [9:0] ain_code = '0;
   logic       mc_tick;
   logic       busy;
   logic       irq_req;
   logic [9:0] result;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   adc_seq_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_lo_wr (res_lo_wr),
      .start_n   (start_n),
      .ctl_cont  (ctl_cont),
      .ctl_long  (ctl_long),
      .irq_clr   (irq_clr),
      .ain_code  (ain_code),
      .mc_tick   (mc_tick),
      .busy      (busy),
      .irq_req   (irq_req),
      .result    (result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Move to the sample of clock k within a machine cycle (k = 0 is the first clock)
   task automatic to_phase(input int k);
      do @(negedge clk); while (!mc_tick);
      @(negedge clk);
      repeat (k) @(negedge clk);
   endtask

   task automatic bus_pulse();
      res_lo_wr = 1'b1;
      @(negedge clk);
      res_lo_wr = 1'b0;
   endtask

   // Wait for busy to rise; report whether the sample before showed mc_tick
   task automatic await_start(input string req, input int limit);
      bit prev;
      int waited;
      bit seen;
      prev = mc_tick;
      waited = 0;
      seen = 1'b0;
      while (waited < limit && !seen) begin
         @(negedge clk);
         waited++;
         if (busy) seen = 1'b1;
         else prev = mc_tick;
      end
      check(seen, req, "conversion started", int'(seen), 1);
      check(prev, "R3", "start on machine-cycle boundary", int'(prev), 1);
   endtask

   // Count busy samples from the current one; returns at the first idle sample
   task automatic count_busy(input int init, output int len);
      len = init;
      while (len < 400) begin
         @(negedge clk);
         if (busy) len++;
         else break;
      end
   endtask

   task automatic finish_conv(input int init, input int exp_len, input int exp_res,
                              input string req);
      int len;
      count_busy(init, len);
      check(len == exp_len, req, "conversion length", len, exp_len);
      check(result == 10'(exp_res), "R5", "result in write cycle", int'(result), exp_res);
      check(irq_req, "R6", "irq with busy low", int'(irq_req), 1);
   endtask

   task automatic expect_idle(input int n, input string req);
      bit stayed;
      stayed = 1'b1;
      repeat (n) begin
         @(negedge clk);
         if (busy) stayed = 1'b0;
      end
      check(stayed, req, "no further conversion", int'(stayed), 1);
   endtask

   task automatic clear_irq(input string req);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(!irq_req, req, "irq cleared", int'(irq_req), 0);
   endtask

   task automatic t_reset();
      int gap;
      check(!busy && !irq_req && result == 0, "R11", "outputs in reset",
            int'({busy, irq_req}) + int'(result), 0);
      @(negedge clk);
      rst_n = 1'b1;
      check(!busy && !irq_req && result == 0, "R11", "outputs after reset",
            int'({busy, irq_req}) + int'(result), 0);
      do @(negedge clk); while (!mc_tick);
      for (int i = 0; i < 2; i++) begin
         gap = 0;
         do begin @(negedge clk); gap++; end while (!mc_tick);
         check(gap == MC, "R1", "tick period", gap, MC);
      end
   endtask

   task automatic t_bus_short();
      ain_code = 10'h2A5;
      to_phase(2);
      bus_pulse();
      await_start("R2", 20);
      finish_conv(1, SHORT_LEN, 'h2A5, "R4");
      repeat (20) @(negedge clk);
      check(irq_req, "R10", "irq held until cleared", int'(irq_req), 1);
      clear_irq("R10");
   endtask

   task automatic t_long_and_latch();
      ctl_long = 1'b1;
      ain_code = 10'h155;
      to_phase(0);
      bus_pulse();
      await_start("R2", 20);
      finish_conv(1, LONG_LEN, 'h155, "R4");
      clear_irq("R10");
      // length select changed during the run has no effect on it
      ctl_long = 1'b0;
      ain_code = 10'h0F0;
      to_phase(4);
      bus_pulse();
      await_start("R2", 20);
      ctl_long = 1'b1;
      repeat (4) @(negedge clk);
      check(result == 10'h155, "R5", "result held while busy", int'(result), 'h155);
      finish_conv(5, SHORT_LEN, 'h0F0, "R4");
      ctl_long = 1'b0;
      clear_irq("R10");
   endtask

   task automatic t_pin();
      ain_code = 10'h3C3;
      to_phase(1);
      start_n = 1'b0;
      await_start("R2", 12);
      finish_conv(1, SHORT_LEN, 'h3C3, "R2");
      clear_irq("R10");
      start_n = 1'b1;
      expect_idle(30, "R2");
   endtask

   task automatic t_ignore();
      ain_code = 10'h081;
      to_phase(3);
      bus_pulse();
      await_start("R2", 20);
      repeat (9) @(negedge clk);
      bus_pulse();
      start_n = 1'b0;
      finish_conv(11, SHORT_LEN, 'h081, "R9");
      expect_idle(40, "R9");
      start_n = 1'b1;
      clear_irq("R10");
      expect_idle(12, "R9");
   endtask

   task automatic t_cont();
      int gap;
      ctl_cont = 1'b1;
      ain_code = 10'h3FF;
      to_phase(0);
      bus_pulse();
      await_start("R2", 20);
      finish_conv(1, SHORT_LEN, 'h3FF, "R7");
      gap = 1;
      while (gap < 50) begin
         @(negedge clk);
         if (!busy) gap++;
         else break;
      end
      check(gap == MC, "R7", "idle gap in continuous mode", gap, MC);
      ain_code = 10'h001;
      repeat (10) @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(!irq_req, "R10", "irq cleared mid-run", int'(irq_req), 0);
      ctl_cont = 1'b0;
      finish_conv(12, SHORT_LEN, 'h001, "R8");
      expect_idle(40, "R8");
      clear_irq("R10");
   endtask

   initial begin
      t_reset();
      t_bus_short();
      t_long_and_latch();
      t_pin();
      t_ignore();
      t_cont();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule